// File: doc/BRIEF.md
# Quadrature Motion Decoder

This block turns the two phase signals of an incremental shaft encoder into a signed position count. It adds or subtracts one on every edge of either phase, which gives four counts per encoder period. The direction of the last counted step is also an output. All four inputs (two phases, an index mark and a home switch) first pass through a synchronizer and a programmable stability filter, so glitches shorter than the filter length never reach the decoder. An index or home rising edge can each be set to clear the position. A motion watchdog raises a sticky alarm when no counted step arrives within a programmed number of clocks.

Configuration uses a plain single-cycle write port with three registers. The position, direction, error and alarm outputs are plain levels that are valid every cycle. The block has no streaming data path, so it has no valid/ready handshake and applies no back-pressure. The bench treats the phase inputs as levels and expects the filtered result a fixed number of clocks later.

Register select `cfg_addr_i`: 0 is control, 1 is the watchdog timeout, 2 is the clear register. In the control register, bits [3:0] set the filter length, bit 4 enables clearing on index, bit 5 enables clearing on home, and bit 6 enables the watchdog. In the clear register, bit 0 clears the alarm and bit 1 clears the step error.

Top module: `quad_motion_decoder`

## Requirements
- R1: After reset, the position is 0, the direction output is 0, the step error is 0 and the alarm is 0. The filter length is 3 and all enables are off.
- R2: With {A,B} moving through 00→10→11→01→00 (A leads), each single-phase change adds 1 to the position. Each change in the reverse order subtracts 1.
- R3: The direction output is 1 after a counting-up step and 0 after a counting-down step. It holds its value while no valid step occurs.
- R4: A step in which both filtered phases change in the same cycle leaves the position unchanged and sets a sticky step error. Writing 1 to bit 1 of register 2 clears the error.
- R5: A filtered input takes a new raw level only after that level has been sampled on N consecutive clocks. Pulses shorter than N are ignored. N is control bits [3:0], clamped to the range 3 to 10, so a write of 1 gives 3 and a write of 15 gives 10.
- R6: A filtered rising edge on index clears the position to 0 when control bit 4 is 1. When control bit 4 is 0, index has no effect.
- R7: A filtered rising edge on home clears the position to 0 when control bit 5 is 1. When control bit 5 is 0, home has no effect.
- R8: When a clear event and a valid step fall in the same cycle, the position becomes 0. The direction output still follows that step.
- R9: When control bit 6 is 1 and the timeout T in register 1 is nonzero, the alarm rises T clocks after the last counted step, or after the last write to register 0 or 1. Each counted step reloads the count. When T is 0, the alarm never rises.
- R10: The alarm stays high until a write of 1 to bit 0 of register 2 clears it.
- R11: The position wraps modulo 2^16. One down step from 0 gives 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |
| index_i | input | 1 | Index mark, asynchronous |
| home_i | input | 1 | Home switch, asynchronous |
| cfg_we_i | input | 1 | Register write strobe, one cycle |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | 16 | Register write data |
| position_o | output | 16 | Signed position count |
| dir_up_o | output | 1 | Direction of the last counted step, 1 = up |
| step_err_o | output | 1 | Sticky flag for a both-phase step |
| wdog_alarm_o | output | 1 | Sticky alarm for no motion |

## Verification
Two events can land in the same clock: an index clear and a counting step. The index filter and the phase filters have the same length, so the bench changes index and phase B on the same input cycle and both filtered edges reach the counter together. The result is correct when the position reads 0 and the direction output shows the down step that was overridden. A watchdog reload and its expiry can also meet. The bench covers this by stepping at intervals shorter than the timeout and confirming that no alarm appears.

// File: rtl/qmd_pkg.sv
package qmd_pkg;

  localparam int FLT_W   = 4;
  localparam int FLT_MIN = 3;
  localparam int FLT_MAX = 10;

  localparam int CH_A    = 0;
  localparam int CH_B    = 1;
  localparam int CH_IDX  = 2;
  localparam int CH_HOME = 3;
  localparam int N_CH    = 4;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_TMO   = 2'd1,
    SEL_CLEAR = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             wd_en;
    logic             home_en;
    logic             idx_en;
    logic [FLT_W-1:0] flt_len;
  } ctrl_t;

  function automatic logic [FLT_W-1:0] clamp_len(input logic [FLT_W-1:0] v);
    if (v < FLT_W'(FLT_MIN))      return FLT_W'(FLT_MIN);
    else if (v > FLT_W'(FLT_MAX)) return FLT_W'(FLT_MAX);
    else                          return v;
  endfunction

endpackage

// File: rtl/qmd_filter.sv
module qmd_filter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             level_o
);

  logic             sync1_q, sync2_q, out_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      out_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      if (sync2_q == out_q) begin
        cnt_q <= '0;
      end else if (cnt_nxt >= len_i) begin
        out_q <= sync2_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign level_o = out_q;

  // an accepted level must be the one the synchronizer presented
  AST_FLT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (out_q == $past(sync2_q)));  // R5

endmodule

// File: rtl/qmd_decode.sv
module qmd_decode
  import qmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] filt_i,
  output logic            step_valid_o,
  output logic            step_up_o,
  output logic            step_bad_o,
  output logic            idx_rise_o,
  output logic            home_rise_o
);

  logic [N_CH-1:0] prev_q;
  logic [N_CH-1:0] chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= filt_i;
  end

  assign chg          = filt_i ^ prev_q;
  assign step_valid_o = chg[CH_A] ^ chg[CH_B];
  assign step_bad_o   = chg[CH_A] & chg[CH_B];
  // A leading B: the old A level equals the new B level
  assign step_up_o    = (prev_q[CH_A] == filt_i[CH_B]);
  assign idx_rise_o   = filt_i[CH_IDX]  & ~prev_q[CH_IDX];
  assign home_rise_o  = filt_i[CH_HOME] & ~prev_q[CH_HOME];

endmodule

// File: rtl/qmd_counter.sv
module qmd_counter #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid_i,
  input  logic             step_up_i,
  input  logic             step_bad_i,
  input  logic             clr_i,
  input  logic             err_clr_i,
  output logic [POS_W-1:0] pos_o,
  output logic             dir_up_o,
  output logic             err_o
);

  logic [POS_W-1:0] pos_q;
  logic             dir_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      dir_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (clr_i)             pos_q <= '0;
      else if (step_valid_i) pos_q <= step_up_i ? pos_q + 1'b1 : pos_q - 1'b1;

      if (step_valid_i) dir_q <= step_up_i;

      if (step_bad_i)     err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign pos_o    = pos_q;
  assign dir_up_o = dir_q;
  assign err_o    = err_q;

  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) |-> (pos_q == $past(pos_q) || pos_q == $past(pos_q) + 1'b1 ||
                       pos_q == $past(pos_q) - 1'b1));  // R2
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_bad_i) && !$past(clr_i)) |-> $stable(pos_q));  // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_q) && !$past(err_clr_i)) |-> err_q);  // R4
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> (pos_q == '0));  // R8

endmodule

// File: rtl/qmd_watchdog.sv
module qmd_watchdog #(
  parameter int WD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [WD_W-1:0] timeout_i,
  input  logic            reload_i,
  input  logic            step_i,
  input  logic            alarm_clr_i,
  output logic            alarm_o
);

  logic [WD_W-1:0] cnt_q;
  logic            alarm_q;
  logic            fire;

  assign fire = en_i && !step_i && !reload_i && (cnt_q == WD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (!en_i)                  cnt_q <= '0;
      else if (step_i || reload_i) cnt_q <= timeout_i;
      else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;

      if (fire)             alarm_q <= 1'b1;
      else if (alarm_clr_i) alarm_q <= 1'b0;
    end
  end

  assign alarm_o = alarm_q;

  AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> ($past(cnt_q) == WD_W'(1) && $past(en_i)));  // R9
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alarm_q) && !$past(alarm_clr_i)) |-> alarm_q);  // R10

endmodule

// File: rtl/quad_motion_decoder.sv
module quad_motion_decoder
  import qmd_pkg::*;
#(
  parameter int POS_W  = 16,
  parameter int WD_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_a_i,
  input  logic              phase_b_i,
  input  logic              index_i,
  input  logic              home_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [POS_W-1:0]  position_o,
  output logic              dir_up_o,
  output logic              step_err_o,
  output logic              wdog_alarm_o
);

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t           ctrl_q;
  logic [WD_W-1:0] tmo_q;
  logic            reload_q;
  reg_sel_e        sel;
  logic            wr_ctrl, wr_tmo, wr_clear;
  logic            alarm_clr, err_clr;

  logic [N_CH-1:0] raw, filt;
  logic            step_valid, step_up, step_bad, idx_rise, home_rise, clr_evt;

  assign sel      = reg_sel_e'(cfg_addr_i);
  assign wr_ctrl  = cfg_we_i && (sel == SEL_CTRL);
  assign wr_tmo   = cfg_we_i && (sel == SEL_TMO);
  assign wr_clear = cfg_we_i && (sel == SEL_CLEAR);
  assign alarm_clr = wr_clear && cfg_wdata_i[0];
  assign err_clr   = wr_clear && cfg_wdata_i[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.wd_en   <= 1'b0;
      ctrl_q.home_en <= 1'b0;
      ctrl_q.idx_en  <= 1'b0;
      ctrl_q.flt_len <= FLT_W'(FLT_MIN);
      tmo_q          <= '0;
      reload_q       <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.wd_en   <= cfg_wdata_i[CTRL_W-1];
        ctrl_q.home_en <= cfg_wdata_i[CTRL_W-2];
        ctrl_q.idx_en  <= cfg_wdata_i[CTRL_W-3];
        ctrl_q.flt_len <= clamp_len(cfg_wdata_i[FLT_W-1:0]);
      end
      if (wr_tmo) tmo_q <= cfg_wdata_i[WD_W-1:0];
      // reload one cycle later so the new register values are in place
      reload_q <= wr_ctrl | wr_tmo;
    end
  end

  assign raw[CH_A]    = phase_a_i;
  assign raw[CH_B]    = phase_b_i;
  assign raw[CH_IDX]  = index_i;
  assign raw[CH_HOME] = home_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_flt
    qmd_filter #(.CNT_W(FLT_W)) u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (raw[g]),
      .len_i   (ctrl_q.flt_len),
      .level_o (filt[g])
    );
  end

  qmd_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .filt_i       (filt),
    .step_valid_o (step_valid),
    .step_up_o    (step_up),
    .step_bad_o   (step_bad),
    .idx_rise_o   (idx_rise),
    .home_rise_o  (home_rise)
  );

  assign clr_evt = (ctrl_q.idx_en & idx_rise) | (ctrl_q.home_en & home_rise);

  qmd_counter #(.POS_W(POS_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_valid_i (step_valid),
    .step_up_i    (step_up),
    .step_bad_i   (step_bad),
    .clr_i        (clr_evt),
    .err_clr_i    (err_clr),
    .pos_o        (position_o),
    .dir_up_o     (dir_up_o),
    .err_o        (step_err_o)
  );

  qmd_watchdog #(.WD_W(WD_W)) u_wd (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (ctrl_q.wd_en),
    .timeout_i   (tmo_q),
    .reload_i    (reload_q),
    .step_i      (step_valid),
    .alarm_clr_i (alarm_clr),
    .alarm_o     (wdog_alarm_o)
  );

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.flt_len >= FLT_W'(FLT_MIN)) && (ctrl_q.flt_len <= FLT_W'(FLT_MAX)));  // R5
  AST_IDX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idx_rise) && !$past(ctrl_q.idx_en) && !$past(ctrl_q.home_en) && !$past(step_valid))
      |-> $stable(position_o));  // R6

endmodule

// File: tb/quad_motion_decoder_bench.sv
module quad_motion_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_r = 1'b0, b_r = 1'b0, idx_r = 1'b0, home_r = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] pos;
  logic        dir, err, alarm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_motion_decoder u_quad_motion_decoder (
    .clk (clk), .rst_n (rst_n),
    .phase_a_i (a_r), .phase_b_i (b_r), .index_i (idx_r), .home_i (home_r),
    .cfg_we_i (we), .cfg_addr_i (addr), .cfg_wdata_i (wdata),
    .position_o (pos), .dir_up_o (dir), .step_err_o (err), .wdog_alarm_o (alarm)
  );

  // {A, B, expected position, expected direction, expected error}
  localparam logic [19:0] VEC [12] = '{
    {1'b1, 1'b0, 16'd1, 1'b1, 1'b0},
    {1'b1, 1'b1, 16'd2, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'd3, 1'b1, 1'b0},
    {1'b0, 1'b0, 16'd4, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'd5, 1'b1, 1'b0},
    {1'b0, 1'b0, 16'd4, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'd3, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'd2, 1'b0, 1'b0},
    {1'b0, 1'b0, 16'd2, 1'b0, 1'b1},
    {1'b0, 1'b1, 16'd1, 1'b0, 1'b1},
    {1'b0, 1'b0, 16'd2, 1'b1, 1'b1},
    {1'b1, 1'b0, 16'd3, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; a_r = 0; b_r = 0; idx_r = 0; home_r = 0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
  endtask

  // pulse on A of width w clocks, position sampled after edge samp
  task automatic pulse_a(input int w, input int samp, input logic [15:0] exp, input string tag);
    a_r = 1'b1;
    wait_n(w);
    a_r = 1'b0;
    wait_n(samp - w);
    chk(tag, pos, exp);
    wait_n(30);
    chk({tag, " settle"}, pos, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    // R1 reset state
    chk("R1 position", pos, 0);
    chk("R1 dir", dir, 0);
    chk("R1 err", err, 0);
    chk("R1 alarm", alarm, 0);
    rst_n = 1'b1;
    wait_n(2);

    // R2 R3 R4 vector walk
    for (int i = 0; i < 12; i++) begin
      a_r = VEC[i][19];
      b_r = VEC[i][18];
      wait_n(12);
      chk($sformatf("R2 position vec %0d", i), pos, VEC[i][17:2]);
      chk($sformatf("R3 dir vec %0d", i), dir, VEC[i][1]);
      chk($sformatf("R4 err vec %0d", i), err, VEC[i][0]);
    end
    wr(2'd2, 16'h0002);
    wait_n(2);
    chk("R4 err cleared", err, 0);
    chk("R4 position kept", pos, 16'd3);

    // R11 wrap
    do_reset();
    b_r = 1'b1; wait_n(12);
    chk("R11 wrap below zero", pos, 16'hFFFF);
    b_r = 1'b0; wait_n(12);
    chk("R11 wrap back", pos, 16'h0000);

    // R5 filter length and clamp
    pulse_a(2, 7, 16'd0, "R5 len3 short");
    pulse_a(3, 7, 16'd1, "R5 len3 exact");
    wr(2'd0, 16'h0005);
    pulse_a(4, 9, 16'd0, "R5 len5 short");
    pulse_a(5, 9, 16'd1, "R5 len5 exact");
    wr(2'd0, 16'h0001);
    pulse_a(2, 7, 16'd0, "R5 clamp low short");
    pulse_a(3, 7, 16'd1, "R5 clamp low exact");
    wr(2'd0, 16'h000F);
    pulse_a(9, 14, 16'd0, "R5 clamp high short");
    pulse_a(10, 14, 16'd1, "R5 clamp high exact");
    wr(2'd0, 16'h0003);

    // R6 index clear
    a_r = 1'b1; wait_n(12);
    b_r = 1'b1; wait_n(12);
    chk("R6 setup", pos, 16'd2);
    idx_r = 1'b1; wait_n(12);
    chk("R6 index ignored when disabled", pos, 16'd2);
    idx_r = 1'b0; wait_n(12);
    wr(2'd0, 16'h0013);
    idx_r = 1'b1; wait_n(12);
    chk("R6 index clears", pos, 16'd0);
    idx_r = 1'b0; wait_n(12);

    // R7 home clear (state 11 -> 01 counts up)
    a_r = 1'b0; wait_n(12);
    chk("R7 setup", pos, 16'd1);
    wr(2'd0, 16'h0003);
    home_r = 1'b1; wait_n(12);
    chk("R7 home ignored when disabled", pos, 16'd1);
    home_r = 1'b0; wait_n(12);
    wr(2'd0, 16'h0023);
    home_r = 1'b1; wait_n(12);
    chk("R7 home clears", pos, 16'd0);
    home_r = 1'b0; wait_n(12);

    // R8 clear and step in the same cycle
    wr(2'd0, 16'h0013);
    b_r = 1'b0; wait_n(12);
    chk("R8 setup position", pos, 16'd1);
    chk("R8 setup dir", dir, 1);
    idx_r = 1'b1; b_r = 1'b1; wait_n(12);
    chk("R8 clear wins", pos, 16'd0);
    chk("R8 dir follows step", dir, 0);
    idx_r = 1'b0; wait_n(12);

    // R9 R10 watchdog
    wr(2'd1, 16'd40);
    wr(2'd0, 16'h0043);
    wait_n(30);
    chk("R9 alarm before timeout", alarm, 0);
    wait_n(20);
    chk("R9 alarm after timeout", alarm, 1);
    wait_n(50);
    chk("R10 alarm sticky", alarm, 1);
    wr(2'd2, 16'h0001);
    wait_n(2);
    chk("R10 alarm cleared", alarm, 0);
    for (int k = 0; k < 5; k++) begin
      b_r = ~b_r;
      wait_n(20);
    end
    chk("R9 steps reload", alarm, 0);
    wait_n(60);
    chk("R9 alarm after motion stops", alarm, 1);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'h0001);
    wait_n(100);
    chk("R9 zero timeout never fires", alarm, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule